// File: doc/BRIEF.md
# Packet Traceback Control Generator

This block sits in front of a block-mode convolutional decoder and produces the framing controls that the decoder needs for each packet. Soft symbols arrive as a pair, qualified by a valid flag. A start request on a valid symbol opens a packet. At that moment the block captures the packet length and the traceback length. It forwards the symbol pair through one register stage. On the output side it marks the first symbol of the packet with a one-cycle start marker, so the decoder builds its trellis from a forced state. It then raises a traceback-block strobe over the final portion of the packet.

The strobed tail is as long as the remainder of the packet length divided by the traceback length. When that remainder is zero, the tail is one full traceback length. A packet no longer than one traceback length is strobed over its whole span. In that case the strobe rises together with the start marker. The gap before the strobe can be any number of symbols. The block finds the start of the tail by tracking traceback-sized chunks from the front of the packet. The tail begins at the first chunk boundary from which no more than one traceback length of symbols remains, so no divider is needed. An error pulse flags two conditions: a zero length, and a start request that arrives while a packet is still open.

The controller has four states, held in `tfg_state_e`:
- `ST_IDLE`: no packet is open.
- `ST_LEAD`: inside a packet, before the tail.
- `ST_TAIL`: strobing the tail.
- `ST_BLIND`: a packet with a zero traceback length runs its course with no strobe.

All transitions happen only on valid symbols. The transitions are:
- `ST_IDLE` to `ST_LEAD`: start, both lengths nonzero, and packet length greater than the traceback length.
- `ST_IDLE` to `ST_TAIL`: start, both lengths nonzero, and packet length from 2 up to the traceback length.
- `ST_IDLE` to `ST_BLIND`: start, zero traceback length, and packet length of at least 2.
- `ST_IDLE` to `ST_IDLE`: start with a packet length of 0 or 1.
- `ST_LEAD` to `ST_TAIL`: the symbol opens a chunk and the remaining count is within one traceback length.
- `ST_LEAD` to `ST_IDLE`: that tail-opening symbol is also the last symbol.
- `ST_TAIL` to `ST_IDLE`: the last symbol of the packet.
- `ST_BLIND` to `ST_IDLE`: the last symbol of the packet.

Top module: `trace_frame_gen`

## Requirements
- R1: While reset is held and on the first cycle after reset, `out_valid`, `out_start`, `out_tb_block` and `out_err` are 0.
- R2: `out_valid`, `out_sym_a` and `out_sym_b` repeat `in_valid`, `sym_a` and `sym_b` one clock later. This holds inside and outside packets.
- R3: A valid symbol with `in_start` high while no packet is open opens a packet. That symbol appears one cycle later with `out_start` high. No other output symbol carries `out_start`.
- R4: For a packet with nonzero lengths P and T and a nonzero P mod T, `out_tb_block` is high on exactly the last P mod T valid symbols of the packet. It is low on the cycle after the last symbol.
- R5: When P mod T is zero, `out_tb_block` is high on exactly the last T valid symbols of the packet.
- R6: When P is no greater than T, `out_tb_block` is high on every symbol of the packet. This includes the first, in the same output cycle as `out_start`.
- R7: P and T are captured on the opening symbol. Changes on `pkt_len` and `tb_len` during the packet have no effect on that packet.
- R8: A zero `pkt_len` or a zero `tb_len` on the opening symbol sets `out_err` on that symbol's output cycle, and `out_tb_block` stays low for the whole packet. A zero P makes a one-symbol packet. A zero T with a nonzero P keeps the packet open for P symbols.
- R9: A valid start request inside an open packet sets `out_err` on its output cycle. It does not set `out_start`. The symbol counts as an ordinary symbol of the current packet.
- R10: Cycles with `in_valid` low do not advance the packet, and `in_start` is ignored on them. The output cycle that follows has `out_valid`, `out_start`, `out_tb_block` and `out_err` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Symbol pair valid |
| in_start | input | 1 | Packet start request |
| sym_a | input | SW | First soft symbol |
| sym_b | input | SW | Second soft symbol |
| pkt_len | input | LW | Packet length in symbols, captured on start |
| tb_len | input | LW | Traceback length in symbols, captured on start |
| out_valid | output | 1 | Delayed symbol valid |
| out_sym_a | output | SW | Delayed first symbol |
| out_sym_b | output | SW | Delayed second symbol |
| out_start | output | 1 | Packet start marker |
| out_tb_block | output | 1 | Traceback-block strobe |
| out_err | output | 1 | Error pulse |

## Verification
The start marker and the traceback strobe land in the same output cycle whenever a packet fits within one traceback length. The bench provokes this with packets of 1, 3 and 8 symbols against traceback lengths of 5 and 8, and it expects both flags high on the first symbol. The error pulse can also coincide with the strobe when a premature start lands inside the tail. The bench provokes this by restarting inside a packet and checks that the strobe count derived from the modulo formula is unchanged while only `out_err` rises.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TAIL  = 2'd2,
        ST_BLIND = 2'd3
    } tfg_state_e;
endpackage

// File: rtl/tfg_sym_pipe.sv
module tfg_sym_pipe #(
    parameter int SW   = 4,
    parameter int NSYM = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSYM-1:0][SW-1:0]   din,
    output logic [NSYM-1:0][SW-1:0]   dout
);
    for (genvar g = 0; g < NSYM; g++) begin : g_lane
        logic [SW-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= din[g];
        end
        assign dout[g] = lane_q;
    end
endmodule

// File: rtl/tfg_span_cnt.sv
module tfg_span_cnt #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [LW-1:0] len_in,
    input  logic [LW-1:0] tb_in,
    output logic          last_sym,
    output logic          blk_head,
    output logic          fits
);
    logic [LW-1:0] rem_q;
    logic [LW-1:0] phase_q;
    logic [LW-1:0] tbq_q;
    logic [LW:0]   phase_inc;

    assign phase_inc = {1'b0, phase_q} + {{LW{1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            phase_q <= '0;
            tbq_q   <= '0;
        end else if (load) begin
            rem_q   <= len_in - LW'(1);
            tbq_q   <= tb_in;
            phase_q <= (tb_in <= LW'(1)) ? '0 : LW'(1);
        end else if (step) begin
            rem_q   <= rem_q - LW'(1);
            phase_q <= (phase_inc == {1'b0, tbq_q}) ? '0 : phase_inc[LW-1:0];
        end
    end

    assign last_sym = (rem_q == LW'(1));
    assign blk_head = (phase_q == '0);
    assign fits     = (rem_q <= tbq_q);

    // R4
    rem_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem_q != '0));
endmodule

// File: rtl/trace_frame_gen.sv
module trace_frame_gen
    import tfg_pkg::*;
#(
    parameter int SW = 4,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic [SW-1:0] sym_a,
    input  logic [SW-1:0] sym_b,
    input  logic [LW-1:0] pkt_len,
    input  logic [LW-1:0] tb_len,
    output logic          out_valid,
    output logic [SW-1:0] out_sym_a,
    output logic [SW-1:0] out_sym_b,
    output logic          out_start,
    output logic          out_tb_block,
    output logic          out_err
);
    localparam int NSYM = 2;

    tfg_state_e state, nxt;
    logic mark, strobe, err_c, load, step;
    logic last_sym, blk_head, fits, bad_len;
    logic [NSYM-1:0][SW-1:0] sym_in, sym_out;

    assign sym_in    = {sym_b, sym_a};
    assign out_sym_a = sym_out[0];
    assign out_sym_b = sym_out[1];
    assign bad_len   = (pkt_len == '0) || (tb_len == '0);

    tfg_sym_pipe #(.SW(SW), .NSYM(NSYM)) u_pipe (
        .clk (clk), .rst_n (rst_n), .din (sym_in), .dout (sym_out)
    );

    tfg_span_cnt #(.LW(LW)) u_cnt (
        .clk (clk), .rst_n (rst_n), .load (load), .step (step),
        .len_in (pkt_len), .tb_in (tb_len),
        .last_sym (last_sym), .blk_head (blk_head), .fits (fits)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt    = state;
        mark   = 1'b0;
        strobe = 1'b0;
        err_c  = 1'b0;
        load   = 1'b0;
        step   = 1'b0;
        if (in_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (in_start) begin
                        mark   = 1'b1;
                        load   = 1'b1;
                        err_c  = bad_len;
                        strobe = !bad_len && (pkt_len <= tb_len);
                        if (pkt_len <= LW'(1))       nxt = ST_IDLE;
                        else if (bad_len)            nxt = ST_BLIND;
                        else if (pkt_len <= tb_len)  nxt = ST_TAIL;
                        else                         nxt = ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    step  = 1'b1;
                    err_c = in_start;
                    if (blk_head && fits) begin
                        strobe = 1'b1;
                        nxt    = last_sym ? ST_IDLE : ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    step   = 1'b1;
                    strobe = 1'b1;
                    err_c  = in_start;
                    if (last_sym) nxt = ST_IDLE;
                end
                ST_BLIND: begin
                    step  = 1'b1;
                    err_c = in_start;
                    if (last_sym) nxt = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_start    <= 1'b0;
            out_tb_block <= 1'b0;
            out_err      <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            out_start    <= mark;
            out_tb_block <= strobe;
            out_err      <= err_c;
        end
    end

    // R8
    zero_len_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_valid && in_start && bad_len)
        |=> (out_err && out_start && !out_tb_block));

    // R9
    early_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && in_valid && in_start) |=> (out_err && !out_start));

    // R4
    tail_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(in_valid && in_start)) |=> (!out_tb_block && !out_start));

    // R10
    idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_tb_block && !out_start && !out_err));

    // R6
    single_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_valid && in_start && !bad_len && pkt_len <= tb_len)
        |=> (out_start && out_tb_block));
endmodule

// File: tb/test_trace_frame_gen.sv
module test_trace_frame_gen;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 4;
    localparam int LW = 8;
    localparam int NVEC = 8;
    // {gaps, packet length, traceback length}
    localparam logic [16:0] VEC [0:NVEC-1] = '{
        {1'b0, 8'd10, 8'd4}, {1'b0, 8'd12, 8'd4}, {1'b0, 8'd3, 8'd8},
        {1'b0, 8'd8,  8'd8}, {1'b0, 8'd1,  8'd5}, {1'b0, 8'd7, 8'd1},
        {1'b1, 8'd9,  8'd4}, {1'b1, 8'd13, 8'd5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_start = 1'b0;
    logic [SW-1:0] sym_a = '0, sym_b = '0;
    logic [LW-1:0] pkt_len = '0, tb_len = '0;
    logic out_valid, out_start, out_tb_block, out_err;
    logic [SW-1:0] out_sym_a, out_sym_b;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_frame_gen #(.SW(SW), .LW(LW)) i_trace_frame_gen (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_start (in_start),
        .sym_a (sym_a), .sym_b (sym_b), .pkt_len (pkt_len), .tb_len (tb_len),
        .out_valid (out_valid), .out_sym_a (out_sym_a), .out_sym_b (out_sym_b),
        .out_start (out_start), .out_tb_block (out_tb_block), .out_err (out_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(logic v, logic s, logic [SW-1:0] a, logic [SW-1:0] b,
                       logic [LW-1:0] pl, logic [LW-1:0] tl);
        @(negedge clk);
        in_valid = v; in_start = s; sym_a = a; sym_b = b; pkt_len = pl; tb_len = tl;
        @(posedge clk);
        #1;
    endtask

    task automatic run_pkt(int pl, int tl, bit gaps, bit chg, int restart_at, string req);
        int  n   = (pl == 0) ? 1 : pl;
        bit  bad = (pl == 0) || (tl == 0);
        int  len = bad ? 0 : ((pl % tl == 0) ? tl : pl % tl);
        int  cnt = 0;
        for (int i = 0; i < n; i++) begin
            logic [SW-1:0] a = SW'(i * 3 + pl);
            logic [SW-1:0] b = ~SW'(i + tl);
            logic [LW-1:0] lp = (chg && i > 0) ? LW'(pl + 5) : LW'(pl);
            logic [LW-1:0] lt = (chg && i > 0) ? LW'(tl + 3) : LW'(tl);
            bit st  = (i == 0) || (i == restart_at);
            bit etb = !bad && (i >= pl - len);
            bit eer = (i == 0) ? bad : (i == restart_at);
            if (gaps && (i % 2 == 1)) begin
                cyc(1'b0, 1'b1, a, b, lp, lt);
                check("R10 gap cycle", {out_valid, out_start, out_tb_block, out_err}, 4'b0);
            end
            cyc(1'b1, st, a, b, lp, lt);
            check({req, " R2 R3 symbol"},
                  {out_valid, out_start, out_tb_block, out_err, out_sym_a, out_sym_b},
                  {1'b1, (i == 0), etb, eer, a, b});
            cnt += int'(out_tb_block);
        end
        check({req, " strobe count"}, cnt, len);
        cyc(1'b0, 1'b0, '0, '0, '0, '0);
        check({req, " R4 after last"}, {out_valid, out_start, out_tb_block, out_err}, 4'b0);
    endtask

    function automatic string vec_tag(int pl, int tl);
        if (pl <= tl)        return "R6";
        if (pl % tl == 0)    return "R5";
        return "R4";
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs stay low under reset even with live inputs
        in_valid = 1'b1; in_start = 1'b1; pkt_len = 8'd4; tb_len = 8'd2;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", {out_valid, out_start, out_tb_block, out_err}, 4'b0);
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after reset", {out_valid, out_start, out_tb_block, out_err}, 4'b0);

        for (int k = 0; k < NVEC; k++) begin
            int pl = int'(VEC[k][15:8]);
            int tl = int'(VEC[k][7:0]);
            run_pkt(pl, tl, VEC[k][16], 1'b0, -1, vec_tag(pl, tl));
        end

        // R2: symbols outside a packet pass through
        cyc(1'b1, 1'b0, 4'hA, 4'h5, 8'd3, 8'd2);
        check("R2 outside packet",
              {out_valid, out_start, out_tb_block, out_err, out_sym_a, out_sym_b},
              {4'b1000, 4'hA, 4'h5});

        // R7: lengths changed mid-packet
        run_pkt(10, 4, 1'b0, 1'b1, -1, "R7");
        run_pkt(6, 6, 1'b0, 1'b1, -1, "R7");

        // R9: premature start inside lead, then inside tail
        run_pkt(9, 4, 1'b0, 1'b0, 3, "R9");
        run_pkt(9, 4, 1'b0, 1'b0, 8, "R9");

        // R8: zero lengths
        run_pkt(0, 4, 1'b0, 1'b0, -1, "R8");
        run_pkt(5, 0, 1'b0, 1'b0, -1, "R8");
        run_pkt(11, 3, 1'b1, 1'b0, -1, "R8 recovery R4");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule